// File: doc/BRIEF.md
# Keyed ISA I/O Window Configurator

This block sits on a legacy ISA I/O bus in front of an adapter that comes out of reset with no I/O window. Software wakes it by writing a fixed five-byte key. The first byte goes to port 0x779 and the remaining four go, in order, to port 0x379. The next write to 0x379 is a packed configuration byte. That byte picks one of eight base addresses from a fixed table, selects an interrupt routing code, and enables or disables the card.

Once the card is enabled, the block raises a chip-select for the sixteen bytes from the chosen base upward, and reports the interrupt line the card should drive. It also answers a small presence probe at offset 9 of the window, so the host can confirm the card now sits where it was placed. While the card is disabled, every read returns 0xFF, the value of an undriven bus. The key is chosen at build time from two supported sets, and the card can be moved or switched off at any time by repeating the key followed by a new configuration byte.

Top module: `isa_magic_cfg`

## Requirements
- R1: After reset the card is disabled: `card_en`=0, `win_cs`=0, `irq_num`=0, and reads at any address return 0xFF.
- R2: A full key followed by a configuration byte with bit 7 set enables the card. Bits 2:0 pick the base, where index 0..7 maps to 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348, 0x350. `win_cs` is high exactly for addresses base through base+15.
- R3: A write to 0x379 carrying anything other than the next expected key byte sends the matcher back to idle. The remaining key bytes and the configuration byte that follow then have no effect.
- R4: A write to 0x779 always restarts matching. With the first key byte it begins a new match, and with any other value it leaves the matcher idle.
- R5: A configuration byte with bit 7 clear disables the card. `win_cs` stays low, and reads in every table window return 0xFF.
- R6: Bits 6:4 of the configuration byte are the interrupt code. `irq_num` shows code 2 as line 9, code 0 as no line (0), and any other code as its own value. `irq_num` is 0 while the card is disabled.
- R7: Offset 9 of the enabled window is a probe register. Bit 7 is read back as written, bits 6:0 read as 0, so writing 0xC0 reads back 0x80. Other window offsets read 0xFF from this block.
- R8: Repeating the key followed by a new configuration byte moves the window to the new base.
- R9: A write to 0x379 while the matcher is idle does not change the configuration.
- R10: Parameter `KEY_SEL` picks the key: 0 selects 0x59,0xB9,0xC5,0xAE,0xA6 and 1 selects 0x0F,0x22,0xF0,0x20,0x80. The other set never unlocks the card.
- R11: Writes to ports other than 0x779 and 0x379 in the middle of a key do not disturb the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when nothing answers |
| win_cs | output | 1 | Chip-select for the 16-byte register window |
| irq_num | output | 4 | Routed interrupt line, 0 for none |
| card_en | output | 1 | Card enabled |

## Verification
The hardest situation to reach is a key that fails partway through. It leaves no visible trace until a configuration byte that would otherwise be accepted arrives and is ignored. The stimulus first enables the card at a known base. It then sends keys that break at the third byte, keys interrupted by a restart on 0x779, and keys with stray port writes in the middle. Each of these is followed by a configuration byte naming a different base, and the chip-select is probed at both the old and the new base to see whether that byte took effect. A second instance built with the other key set shares the same bus, so every sequence also shows that the foreign key leaves that instance dark.

// File: rtl/isa_cfg_pkg.sv
package isa_cfg_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int KEY_LEN   = 5;
    localparam int N_BASES   = 8;
    localparam int IDX_W     = $clog2(N_BASES);
    localparam int WIN_BYTES = 16;
    localparam int IRQ_W     = 4;

    localparam logic [ADDR_W-1:0] HEAD_PORT = 16'h0779;
    localparam logic [ADDR_W-1:0] TAIL_PORT = 16'h0379;
    localparam logic [ADDR_W-1:0] PROBE_OFS = 16'd9;
    localparam logic [DATA_W-1:0] BUS_IDLE  = 8'hFF;

    // Matcher progress: value equals the number of key bytes already matched.
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_K1    = 3'd1,
        SEQ_K2    = 3'd2,
        SEQ_K3    = 3'd3,
        SEQ_K4    = 3'd4,
        SEQ_ARMED = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic             enable;
        logic [2:0]       irq_code;
        logic             spare;
        logic [IDX_W-1:0] base_idx;
    } cfg_byte_t;

    function automatic logic [DATA_W-1:0] key_byte(input int sel, input int pos);
        logic [DATA_W-1:0] k;
        if (sel == 0) begin
            case (pos)
                0: k = 8'h59;
                1: k = 8'hB9;
                2: k = 8'hC5;
                3: k = 8'hAE;
                default: k = 8'hA6;
            endcase
        end else begin
            case (pos)
                0: k = 8'h0F;
                1: k = 8'h22;
                2: k = 8'hF0;
                3: k = 8'h20;
                default: k = 8'h80;
            endcase
        end
        return k;
    endfunction

    function automatic logic [ADDR_W-1:0] base_addr(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] b;
        case (idx)
            3'd0: b = 16'h0280;
            3'd1: b = 16'h0290;
            3'd2: b = 16'h0300;
            3'd3: b = 16'h0310;
            3'd4: b = 16'h0330;
            3'd5: b = 16'h0340;
            3'd6: b = 16'h0348;
            default: b = 16'h0350;
        endcase
        return b;
    endfunction

    // Code 2 stands for the cascaded line 9; code 0 means no line.
    function automatic logic [IRQ_W-1:0] irq_line(input logic [2:0] code);
        logic [IRQ_W-1:0] n;
        if (code == 3'd2) n = 4'd9;
        else              n = {1'b0, code};
        return n;
    endfunction

endpackage

// File: rtl/ucfg_unlock.sv
module ucfg_unlock
    import isa_cfg_pkg::*;
#(
    parameter int KEY_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cfg_load,
    output seq_state_t        state
);

    logic [DATA_W-1:0] keys [KEY_LEN];

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign keys[g] = key_byte(KEY_SEL, g);
    end

    logic       hit_head;
    logic       hit_tail;
    seq_state_t nxt;

    assign hit_head = wr_stb && (addr == HEAD_PORT);
    assign hit_tail = wr_stb && (addr == TAIL_PORT);

    always_comb begin
        nxt = state;
        if (hit_head) begin
            nxt = (wdata == keys[0]) ? SEQ_K1 : SEQ_IDLE;
        end else if (hit_tail) begin
            case (state)
                SEQ_IDLE:  nxt = SEQ_IDLE;
                SEQ_ARMED: nxt = SEQ_IDLE;
                default:   nxt = (wdata == keys[state]) ? seq_state_t'(state + 3'd1)
                                                        : SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= nxt;
    end

    assign cfg_load = hit_tail && (state == SEQ_ARMED);

endmodule

// File: rtl/ucfg_store.sv
module ucfg_store
    import isa_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic              enable,
    output logic [ADDR_W-1:0] base,
    output logic [IRQ_W-1:0]  irq_num
);

    cfg_byte_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_byte_t'(wdata);
    end

    logic unused_spare_bit;
    assign unused_spare_bit = cfg_q.spare;

    assign enable  = cfg_q.enable;
    assign base    = base_addr(cfg_q.base_idx);
    assign irq_num = cfg_q.enable ? irq_line(cfg_q.irq_code) : '0;

endmodule

// File: rtl/ucfg_window.sv
module ucfg_window
    import isa_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic              cs,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] ofs;
    logic              at_probe;
    logic              probe_q;

    // Subtract-and-compare: bases need not be 16-byte aligned.
    assign ofs      = addr - base;
    assign cs       = enable && (ofs < ADDR_W'(WIN_BYTES));
    assign at_probe = cs && (ofs == PROBE_OFS);

    always_ff @(posedge clk) begin
        if (rst)                      probe_q <= 1'b0;
        else if (wr_stb && at_probe)  probe_q <= wdata[DATA_W-1];
    end

    logic unused_wdata_low;
    assign unused_wdata_low = ^wdata[DATA_W-2:0];

    assign rdata = (rd_stb && at_probe) ? {probe_q, {(DATA_W-1){1'b0}}} : BUS_IDLE;

endmodule

// File: rtl/isa_magic_cfg.sv
module isa_magic_cfg
    import isa_cfg_pkg::*;
#(
    parameter int KEY_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              win_cs,
    output logic [IRQ_W-1:0]  irq_num,
    output logic              card_en
);

    logic              cfg_load;
    seq_state_t        seq_state;
    logic [ADDR_W-1:0] win_base;

    ucfg_unlock #(.KEY_SEL(KEY_SEL)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (io_wr),
        .addr     (io_addr),
        .wdata    (io_wdata),
        .cfg_load (cfg_load),
        .state    (seq_state)
    );

    ucfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .wdata   (io_wdata),
        .enable  (card_en),
        .base    (win_base),
        .irq_num (irq_num)
    );

    ucfg_window u_window (
        .clk    (clk),
        .rst    (rst),
        .enable (card_en),
        .base   (win_base),
        .addr   (io_addr),
        .wr_stb (io_wr),
        .rd_stb (io_rd),
        .wdata  (io_wdata),
        .cs     (win_cs),
        .rdata  (io_rdata)
    );

endmodule

// File: rtl/isa_magic_cfg_chk.sv
module isa_magic_cfg_chk
    import isa_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_rdata,
    input logic              win_cs,
    input logic [IRQ_W-1:0]  irq_num,
    input logic              card_en,
    input logic [ADDR_W-1:0] win_base
);

    logic [ADDR_W-1:0] rel;
    assign rel = io_addr - win_base;

    assert_cs_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        win_cs |-> card_en);

    assert_cs_within_window_R2: assert property (@(posedge clk) disable iff (rst)
        win_cs |-> (rel < 16'd16));

    assert_disabled_reads_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!card_en || !io_rd) |-> (io_rdata == 8'hFF));

    assert_irq_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !card_en |-> (irq_num == 4'd0));

    assert_cfg_moves_on_tail_write_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable({card_en, irq_num, win_base}) |-> $past(io_wr && (io_addr == 16'h0379)));

    assert_probe_low_bits_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (io_rd && win_cs && (rel == 16'd9)) |-> (io_rdata[6:0] == 7'd0));

endmodule

bind isa_magic_cfg isa_magic_cfg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_rdata (io_rdata),
    .win_cs   (win_cs),
    .irq_num  (irq_num),
    .card_en  (card_en),
    .win_base (win_base)
);

// File: tb/tb_isa_magic_cfg.sv
module tb_isa_magic_cfg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata, alt_rdata;
    logic        win_cs, alt_cs;
    logic [3:0]  irq_num, alt_irq;
    logic        card_en, alt_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_magic_cfg #(.KEY_SEL(0)) dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .win_cs(win_cs),
        .irq_num(irq_num), .card_en(card_en)
    );

    isa_magic_cfg #(.KEY_SEL(1)) dut_alt (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(alt_rdata), .win_cs(alt_cs),
        .irq_num(alt_irq), .card_en(alt_en)
    );

    function automatic logic [7:0] tb_key(int sel, int i);
        logic [7:0] a [5] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
        logic [7:0] b [5] = '{8'h0F, 8'h22, 8'hF0, 8'h20, 8'h80};
        return (sel == 0) ? a[i] : b[i];
    endfunction

    function automatic logic [15:0] tb_base(int i);
        logic [15:0] t [8] = '{16'h280, 16'h290, 16'h300, 16'h310,
                               16'h330, 16'h340, 16'h348, 16'h350};
        return t[i];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
    endtask

    task automatic bus_read(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0; io_addr = 16'h0;
    endtask

    task automatic cs_at(logic [15:0] a, output logic c);
        @(negedge clk);
        io_addr = a;
        #1 c = win_cs;
        io_addr = 16'h0;
    endtask

    task automatic unlock(int sel, logic [7:0] cfg);
        bus_write(16'h779, tb_key(sel, 0));
        for (int i = 1; i < 5; i++) bus_write(16'h379, tb_key(sel, i));
        bus_write(16'h379, cfg);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic c;
        chk("R1 card_en", 16'(card_en), 16'd0);
        chk("R1 irq_num", 16'(irq_num), 16'd0);
        cs_at(16'h280, c);
        chk("R1 cs", 16'(c), 16'd0);
        bus_read(16'h289, d);
        chk("R1 read idle", 16'(d), 16'hFF);
    endtask

    task automatic t_table();
        logic c;
        for (int i = 0; i < 8; i++) begin
            unlock(0, 8'h80 | 8'(i));
            chk("R2 enabled", 16'(card_en), 16'd1);
            cs_at(tb_base(i), c);          chk("R2 cs at base", 16'(c), 16'd1);
            cs_at(tb_base(i) + 16'd15, c); chk("R2 cs at top", 16'(c), 16'd1);
            cs_at(tb_base(i) - 16'd1, c);  chk("R2 cs below", 16'(c), 16'd0);
            cs_at(tb_base(i) + 16'd16, c); chk("R2 cs above", 16'(c), 16'd0);
        end
    endtask

    task automatic t_irq();
        unlock(0, 8'hA0);
        chk("R6 code2 is line9", 16'(irq_num), 16'd9);
        unlock(0, 8'hD0);
        chk("R6 code5", 16'(irq_num), 16'd5);
        unlock(0, 8'h80);
        chk("R6 code0 none", 16'(irq_num), 16'd0);
    endtask

    task automatic t_disable();
        logic [7:0] d; logic c;
        unlock(0, 8'h00);
        chk("R5 disabled", 16'(card_en), 16'd0);
        chk("R6 irq off", 16'(irq_num), 16'd0);
        for (int i = 0; i < 8; i++) begin
            bus_read(tb_base(i) + 16'd9, d);
            chk("R5 read idle", 16'(d), 16'hFF);
            cs_at(tb_base(i), c);
            chk("R5 cs low", 16'(c), 16'd0);
        end
    endtask

    task automatic t_bad_key();
        logic c;
        unlock(0, 8'h80);
        bus_write(16'h779, tb_key(0, 0));
        bus_write(16'h379, tb_key(0, 1));
        bus_write(16'h379, 8'h00);
        bus_write(16'h379, tb_key(0, 3));
        bus_write(16'h379, tb_key(0, 4));
        bus_write(16'h379, 8'h83);
        cs_at(16'h280, c); chk("R3 old base kept", 16'(c), 16'd1);
        cs_at(16'h310, c); chk("R3 new base ignored", 16'(c), 16'd0);
    endtask

    task automatic t_restart();
        logic c;
        bus_write(16'h779, tb_key(0, 0));
        bus_write(16'h379, tb_key(0, 1));
        unlock(0, 8'h81);
        cs_at(16'h290, c); chk("R4 restart unlocks", 16'(c), 16'd1);
        bus_write(16'h779, tb_key(0, 0));
        bus_write(16'h379, tb_key(0, 1));
        bus_write(16'h779, 8'h12);
        for (int i = 2; i < 5; i++) bus_write(16'h379, tb_key(0, i));
        bus_write(16'h379, 8'h82);
        cs_at(16'h290, c); chk("R4 bad head idles", 16'(c), 16'd1);
        cs_at(16'h300, c); chk("R4 bad head no move", 16'(c), 16'd0);
    endtask

    task automatic t_stray();
        logic c;
        bus_write(16'h779, tb_key(0, 0));
        bus_write(16'h379, tb_key(0, 1));
        bus_write(16'h378, 8'h00);
        bus_write(16'h778, 8'h55);
        for (int i = 2; i < 5; i++) bus_write(16'h379, tb_key(0, i));
        bus_write(16'h379, 8'h82);
        cs_at(16'h300, c); chk("R11 stray ignored", 16'(c), 16'd1);
    endtask

    task automatic t_presence();
        logic [7:0] d;
        bus_read(16'h309, d);
        chk("R7 probe reset", 16'(d), 16'h00);
        bus_write(16'h309, 8'hC0);
        bus_read(16'h309, d);
        chk("R7 probe C0->80", 16'(d), 16'h80);
        bus_read(16'h308, d);
        chk("R7 other offset", 16'(d), 16'hFF);
        bus_write(16'h309, 8'h3F);
        bus_read(16'h309, d);
        chk("R7 probe 3F->00", 16'(d), 16'h00);
    endtask

    task automatic t_reconfig();
        logic c;
        unlock(0, 8'h87);
        cs_at(16'h300, c); chk("R8 old window gone", 16'(c), 16'd0);
        cs_at(16'h35F, c); chk("R8 new window top", 16'(c), 16'd1);
    endtask

    task automatic t_idle_cfg();
        logic c;
        bus_write(16'h379, 8'h85);
        cs_at(16'h350, c); chk("R9 idle cfg ignored", 16'(c), 16'd1);
        chk("R9 irq unchanged", 16'(irq_num), 16'd0);
    endtask

    task automatic t_keyset();
        logic c;
        chk("R10 alt dark", 16'(alt_en), 16'd0);
        unlock(0, 8'h84);
        chk("R10 alt rejects set0", 16'(alt_en), 16'd0);
        unlock(1, 8'hB4);
        chk("R10 alt accepts set1", 16'(alt_en), 16'd1);
        chk("R10 alt irq", 16'(alt_irq), 16'd3);
        @(negedge clk); io_addr = 16'h330; #1 c = alt_cs; io_addr = 16'h0;
        chk("R10 alt cs", 16'(c), 16'd1);
        chk("R10 main irq kept", 16'(irq_num), 16'd0);
        cs_at(16'h330, c); chk("R10 main kept", 16'(c), 16'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_table();
        t_irq();
        t_disable();
        t_bad_key();
        t_restart();
        t_stray();
        t_presence();
        t_reconfig();
        t_idle_cfg();
        t_keyset();
        finish_run();
    end

endmodule